// File: doc/BRIEF.md
# Serial Shift-Register LED Driver

This block feeds an external serial-in, parallel-out shift register that has an output latch and drives a row of indicator LEDs. It watches a parallel word of parameterized width. Whenever that word differs from the last word it sent, the block copies it into a holding register. It then sends the word one bit at a time, most significant bit first, on a serial data line together with a generated shift clock. When the last bit is in, it pulses a storage clock so the external latch shows the new pattern.

Each bit lasts two half-periods of `HALF_BIT` system clocks. The shift clock is low for the first half and high for the second, so its rising edge falls in the middle of a stable data bit. A bit-timing enable, counted from the system clock, paces the data line and the shift clock together. After reset the first transfer is forced, whatever the input holds, so the external register gets a defined value. A change to the input during a transfer is picked up once that transfer has finished.

Top module: `ledSerialDriver`

## Requirements
- R1: A synchronous active-low reset sets `serData`, `shiftClk` and `storeClk` low. They stay low while reset is held.
- R2: After reset is released, one transfer is forced even when `dataIn` is all zeros. The external latch then holds the value of `dataIn`.
- R3: While idle, a transfer starts at the first clock edge at which `dataIn` differs from the last word sent. `storeClk` rises 2*HALF_BIT*WIDTH cycles after that edge, so it is seen high 1+2*HALF_BIT*WIDTH sampling cycles after `dataIn` is driven. The latched value equals that word.
- R4: While `dataIn` equals the last word sent, neither `shiftClk` nor `storeClk` rises, and both stay low.
- R5: Each transfer has exactly WIDTH rising edges of `shiftClk`. The k-th rising edge (k counted from 0) samples bit WIDTH-1-k of the word, so the most significant bit goes first.
- R6: Within a transfer, successive rising edges of `shiftClk` are 2*HALF_BIT cycles apart, and each high phase lasts HALF_BIT cycles. `serData` changes only at the start of a transfer or at a falling edge of `shiftClk`, so it is stable at every rising edge.
- R7: At the clock edge where the last bit's high phase ends, `shiftClk` goes low and `storeClk` goes high. `storeClk` stays high for 2*HALF_BIT cycles, with `shiftClk` low, and then falls. The block is then idle.
- R8: The word is captured when a transfer starts, and input changes during a transfer do not alter that transfer. When the transfer completes, the input is compared with the word just sent. A further transfer follows only if the two differ, so a value that returns to the word in flight causes no second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | WIDTH | Parallel LED pattern |
| serData | output | 1 | Serial data to the external register, most significant bit first |
| shiftClk | output | 1 | Shift clock, rising edge at the middle of each bit |
| storeClk | output | 1 | Storage (latch) clock pulse after the last bit |

## Verification
An input change applied while idle is due as a rising `storeClk` exactly 1+2*HALF_BIT*WIDTH sampling cycles later. The bench records the cycle at which it drives the word and compares it with the cycle at which it sees the latch pulse. Within a transfer, the shift-clock rising edges are due every 2*HALF_BIT cycles, each high phase lasts HALF_BIT cycles, and the latch pulse lasts 2*HALF_BIT cycles. A monitor samples on the falling system-clock edge and measures these run lengths directly. Expected words go into a queue when they are driven and are popped at each latch pulse. After each stimulus that should cause no transfer, the bench waits a fixed span longer than one full transfer and then confirms that no shift or latch edge appeared.

// File: rtl/ledDrvPkg.sv
package ledDrvPkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_LATCH = 2'd3
  } drvState_t;

  // Strobes from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic load;      // capture word, present MSB, shift clock low
    logic clkHigh;   // raise shift clock (middle of bit)
    logic nextBit;   // lower shift clock, present next bit
    logic latchOn;   // lower shift clock, raise storage clock
    logic latchOff;  // lower storage clock
  } drvStrobe_t;
endpackage

// File: rtl/ledBitTick.sv
module ledBitTick #(
  parameter int HALF_BIT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_BIT > 1) ? $clog2(HALF_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_BIT - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN || clear) cnt <= '0;
    else if (run) cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R6: half-bit counter never passes its limit
  a_r6_tick_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);
endmodule

// File: rtl/ledDrvCtrl.sv
module ledDrvCtrl
  import ledDrvPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       changed,
  input  logic       tick,
  output logic       tickRun,
  output logic       tickClear,
  output drvStrobe_t strobe
);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  drvState_t state;
  logic      phase;
  logic [BW-1:0] bitCnt;

  assign tickRun   = (state == ST_SHIFT) || (state == ST_LATCH);
  assign tickClear = strobe.load;

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_INIT:  strobe.load = 1'b1;
      ST_IDLE:  strobe.load = changed;
      ST_SHIFT: if (tick) begin
        if (!phase)                 strobe.clkHigh = 1'b1;
        else if (bitCnt == LAST_BIT) strobe.latchOn = 1'b1;
        else                        strobe.nextBit = 1'b1;
      end
      ST_LATCH: if (tick && phase) strobe.latchOff = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_INIT;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (strobe.load) begin
        state  <= ST_SHIFT;
        phase  <= 1'b0;
        bitCnt <= '0;
      end else if (tickRun && tick) begin
        phase <= ~phase;
        if (strobe.nextBit)  bitCnt <= bitCnt + 1'b1;
        if (strobe.latchOn)  state  <= ST_LATCH;
        if (strobe.latchOff) state  <= ST_IDLE;
      end
    end
  end

  // R4: no change means the block remains idle
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !changed) |=> state == ST_IDLE);
  // R5: bit counter stays within the word
  a_r5_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);
  // R6: one datapath action per cycle
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
  // R7: latch phase always ends in idle
  a_r7_latch_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchOff |=> state == ST_IDLE);
endmodule

// File: rtl/ledDrvPath.sv
module ledDrvPath
  import ledDrvPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  input  drvStrobe_t       strobe,
  output logic             changed,
  output logic             serData,
  output logic             shiftClk,
  output logic             storeClk
);
  logic [WIDTH-1:0] lastSent;
  logic [WIDTH-1:0] shiftReg;

  assign changed = (dataIn != lastSent);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSent <= '0;
      shiftReg <= '0;
      serData  <= 1'b0;
      shiftClk <= 1'b0;
      storeClk <= 1'b0;
    end else begin
      if (strobe.load) begin
        lastSent <= dataIn;
        shiftReg <= dataIn << 1;
        serData  <= dataIn[WIDTH-1];
        shiftClk <= 1'b0;
      end
      if (strobe.clkHigh) shiftClk <= 1'b1;
      if (strobe.nextBit) begin
        shiftClk <= 1'b0;
        serData  <= shiftReg[WIDTH-1];
        shiftReg <= shiftReg << 1;
      end
      if (strobe.latchOn) begin
        shiftClk <= 1'b0;
        storeClk <= 1'b1;
      end
      if (strobe.latchOff) storeClk <= 1'b0;
    end
  end

  // R6: data does not move at a rising shift edge
  a_r6_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> $stable(serData));
  // R7: shift clock low throughout the latch pulse
  a_r7_latch_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    storeClk |-> !shiftClk);
  // R4: a rising shift edge needs a transfer in progress, never at load
  a_r4_rise_in_transfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> $past(!strobe.load));
endmodule

// File: rtl/ledSerialDriver.sv
module ledSerialDriver
  import ledDrvPkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int HALF_BIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dataIn,
  output logic             serData,
  output logic             shiftClk,
  output logic             storeClk
);
  drvStrobe_t strobe;
  logic changed, tick, tickRun, tickClear;

  ledBitTick #(.HALF_BIT(HALF_BIT)) uTick (
    .clk(clk), .rstN(rstN), .clear(tickClear), .run(tickRun), .tick(tick)
  );

  ledDrvCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .changed(changed), .tick(tick),
    .tickRun(tickRun), .tickClear(tickClear), .strobe(strobe)
  );

  ledDrvPath #(.WIDTH(WIDTH)) uPath (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .changed(changed), .serData(serData), .shiftClk(shiftClk),
    .storeClk(storeClk)
  );
endmodule

// File: tb/sim_ledSerialDriver.sv
`timescale 1ns/1ps
module sim_ledSerialDriver;
  localparam int W = 8;
  localparam int H = 2;
  localparam int LAT = 1 + 2*H*W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic serData, shiftClk, storeClk;

  ledSerialDriver #(.WIDTH(W), .HALF_BIT(H)) u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .serData(serData), .shiftClk(shiftClk), .storeClk(storeClk)
  );

  always #5 clk = ~clk;

  int nChecks = 0, nErrors = 0;
  int cyc = 0;
  logic [W-1:0] expQ[$];
  bit armLat = 0;
  int driveCyc = 0;
  bit done = 0;

  // external register model and monitor state
  logic [W-1:0] ext = '0, latched = '0;
  logic prevSclk = 0, prevRclk = 0, prevSdata = 0;
  int riseCnt = 0, latchCnt = 0, bitsThis = 0, highRun = 0, rclkRun = 0, lastRise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      prevSclk = 0; prevRclk = 0; prevSdata = 0; bitsThis = 0; highRun = 0; rclkRun = 0;
    end else begin
      if (shiftClk && !prevSclk) begin
        check(serData == prevSdata, "R6 data stable at rise", serData, prevSdata);
        if (bitsThis > 0) check(cyc - lastRise == 2*H, "R6 bit period", cyc - lastRise, 2*H);
        lastRise = cyc;
        ext = {ext[W-2:0], serData};
        riseCnt++; bitsThis++; highRun = 1;
      end else if (shiftClk) highRun++;
      if (!shiftClk && prevSclk) check(highRun == H, "R6 high phase", highRun, H);
      if (storeClk && !prevRclk) begin
        latched = ext;
        latchCnt++;
        check(bitsThis == W, "R5 rises per transfer", bitsThis, W);
        if (expQ.size() == 0) check(0, "R4 unexpected latch", ext, 0);
        else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(ext == e, "R3 latched word (R5 MSB first, R8)", ext, e);
        end
        if (armLat) begin
          check(cyc - driveCyc == LAT, "R3 latency", cyc - driveCyc, LAT);
          armLat = 0;
        end
        bitsThis = 0; rclkRun = 1;
      end else if (storeClk) rclkRun++;
      if (!storeClk && prevRclk) check(rclkRun == 2*H, "R7 latch width", rclkRun, 2*H);
      prevSclk = shiftClk; prevRclk = storeClk; prevSdata = serData;
    end
  end

  task automatic sendWord(input logic [W-1:0] w, input bit lat);
    @(negedge clk);
    expQ.push_back(w);
    dataIn = w;
    if (lat) begin armLat = 1; driveCyc = cyc; end
  endtask

  task automatic waitDone();
    while (expQ.size() != 0 || storeClk) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic quietSpan(input string tag);
    int r0, l0;
    r0 = riseCnt; l0 = latchCnt;
    repeat (3*LAT) @(negedge clk);
    check(riseCnt == r0, tag, riseCnt, r0);
    check(latchCnt == l0 && !shiftClk && !storeClk, tag, latchCnt, l0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    expQ.push_back('0);           // R2: forced first transfer of all zeros
    repeat (3) begin
      @(negedge clk);
      check({serData, shiftClk, storeClk} == 3'b000, "R1 reset outputs", {serData, shiftClk, storeClk}, 0);
    end
    rstN = 1'b1;
    waitDone();
    check(latchCnt == 1, "R2 forced transfer count", latchCnt, 1);
    check(latched == '0, "R2 forced value", latched, 0);

    sendWord(8'hA5, 1); waitDone();
    sendWord(8'h01, 1); waitDone();
    sendWord(8'h80, 1); waitDone();
    sendWord(8'hFF, 1); waitDone();
    sendWord(8'h00, 1); waitDone();
    check(latched == 8'h00, "R3 final pattern", latched, 0);

    @(negedge clk) dataIn = 8'h00;  // same value again: R4
    quietSpan("R4 no transfer when unchanged");

    sendWord(8'h3C, 0);
    repeat (6) @(negedge clk);
    expQ.push_back(8'hC3); dataIn = 8'hC3;   // R8: queued after current
    waitDone();
    check(latched == 8'hC3, "R8 change taken after transfer", latched, 8'hC3);

    sendWord(8'h5A, 0);
    repeat (6) @(negedge clk) dataIn = 8'h66;
    repeat (6) @(negedge clk);
    dataIn = 8'h5A;                            // back to the word in flight
    waitDone();
    quietSpan("R8 no second transfer");
    check(latched == 8'h5A, "R8 captured word", latched, 8'h5A);

    check(expQ.size() == 0, "R3 all words latched", expQ.size(), 0);
    done = 1;
    summary();
  end
endmodule